// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block counts hardware events from a cache and memory subsystem. Each clock cycle it receives an 8-bit vector of sub-event indications and a value giving how many memory requests are pending. A configuration word selects an event code and a unit mask. It also sets a threshold, an invert flag, an edge flag and an enable flag. From these the block forms a per-cycle event count. It passes that count through the threshold, invert and edge qualifiers, then adds the result to a 48-bit counter.

Software reaches the block through a small register bus. A one-bit write select chooses between the configuration word and the counter, and a one-bit read select picks which of the two drives the read data. A counter write replaces the running value, so software can clear or preload it. A configuration write takes effect on the next cycle. The counter wraps silently modulo 2^48.

Top module: `qual_event_counter`

## Requirements
- R1: After reset, the counter and the configuration word both read as zero.
- R2: Configuration layout: bits [7:0] event code, [15:8] unit mask, [23:16] threshold, bit 24 edge, bit 25 invert, bit 26 enable. With `wr_sel`=0 a write loads the configuration, and with `wr_sel`=1 it loads the counter. `rd_sel`=0 reads the configuration zero-extended and `rd_sel`=1 reads the counter. Read data is combinational.
- R3: Codes 0x22, 0x81 and 0x84 form a per-cycle count equal to the population count of `evt_vec & mask`. With threshold 0 and edge clear, that count is added each cycle.
- R4: With a nonzero threshold and invert clear, the counter adds 1 in each cycle whose per-cycle count is greater than or equal to the threshold.
- R5: With a nonzero threshold and invert set, the counter adds 1 in each cycle whose per-cycle count is strictly below the threshold. With threshold 0, invert has no effect.
- R6: With edge set, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. With threshold 0, the condition is "per-cycle count nonzero". The history of the condition is cleared in any cycle that writes the configuration or has enable clear.
- R7: For code 0x34, the per-cycle count is the population count of `evt_vec[3:0] & mask[3:0]` (the line-state bits). When `mask[7:4]` is nonzero, that count applies only if `evt_vec[7:4] & mask[7:4]` is nonzero, and is zero otherwise. When `mask[3:0]` is zero, the selection is invalid and never increments the counter.
- R8: For codes 0x80 and 0x83, the per-cycle count equals `occ_val`, and `evt_vec` and the mask are ignored.
- R9: Any other event code never increments the counter, whatever the threshold, invert or edge setting.
- R10: With enable clear, the counter holds its value.
- R11: A counter write takes priority over an increment in the same cycle. The counter wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_vec | input | 8 | Per-cycle sub-event indications |
| occ_val | input | OCC_W | Pending request count this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 counter |
| wr_data | input | CTR_W | Write data |
| rd_sel | input | 1 | Read source: 0 configuration, 1 counter |
| rd_data | output | CTR_W | Read data |

## Verification
Inputs present during one cycle affect the counter at the next rising edge, and the new value appears on `rd_data` in the same cycle. A configuration write governs the increment from the cycle after the write. The reset release passes through a two-stage synchronizer, so the block leaves reset two edges after `rst_n` rises. The bench drives every input at a falling edge and samples `rd_data` at the following falling edge. In lockstep it advances an arithmetic model of the counter, the configuration and the edge history. This compares each cycle's outcome exactly and needs no latency slack.

// File: rtl/qec_pkg.sv
package qec_pkg;

  localparam int CODE_W = 8;
  localparam int MASK_W = 8;
  localparam int THR_W  = 8;
  localparam int EVT_W  = MASK_W;
  localparam int POP_W  = $clog2(EVT_W + 1);

  localparam logic [CODE_W-1:0] EV_SNOOP_RESP   = 8'h22;
  localparam logic [CODE_W-1:0] EV_CACHE_LOOKUP = 8'h34;
  localparam logic [CODE_W-1:0] EV_MEM_PEND     = 8'h80;
  localparam logic [CODE_W-1:0] EV_MEM_REQ      = 8'h81;
  localparam logic [CODE_W-1:0] EV_COH_PEND     = 8'h83;
  localparam logic [CODE_W-1:0] EV_COH_REQ      = 8'h84;

  typedef struct packed {
    logic              enable;
    logic              invert;
    logic              edge_en;
    logic [THR_W-1:0]  thresh;
    logic [MASK_W-1:0] umask;
    logic [CODE_W-1:0] code;
  } qec_cfg_t;

  localparam int CFG_W = $bits(qec_cfg_t);

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_COUNT,
    KIND_LOOKUP,
    KIND_OCCUP
  } qec_kind_t;

  function automatic qec_kind_t classify(input logic [CODE_W-1:0] code);
    qec_kind_t k;
    case (code)
      EV_SNOOP_RESP, EV_MEM_REQ, EV_COH_REQ: k = KIND_COUNT;
      EV_CACHE_LOOKUP:                       k = KIND_LOOKUP;
      EV_MEM_PEND, EV_COH_PEND:              k = KIND_OCCUP;
      default:                               k = KIND_NONE;
    endcase
    return k;
  endfunction

  function automatic logic [POP_W-1:0] popcnt(input logic [EVT_W-1:0] v);
    logic [POP_W-1:0] s;
    s = '0;
    for (int i = 0; i < EVT_W; i++) s = s + POP_W'(v[i]);
    return s;
  endfunction

endpackage

// File: rtl/qec_rst_sync.sv
module qec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/qec_event_select.sv
module qec_event_select
  import qec_pkg::*;
#(
  parameter int OCC_W = 6,
  parameter int CNT_W = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic [MASK_W-1:0] umask,
  input  logic [EVT_W-1:0]  evt_vec,
  input  logic [OCC_W-1:0]  occ_val,
  output logic [CNT_W-1:0]  cyc_count,
  output logic              sel_valid
);
  localparam int HALF = EVT_W / 2;

  qec_kind_t        kind;
  logic [EVT_W-1:0] masked;
  logic [EVT_W-1:0] state_bits;
  logic             filt_on;
  logic             filt_hit;
  logic             state_sel;

  always_comb begin
    kind       = classify(code);
    masked     = evt_vec & umask;
    state_bits = {{(EVT_W-HALF){1'b0}}, masked[HALF-1:0]};
    filt_on    = |umask[EVT_W-1:HALF];
    filt_hit   = |masked[EVT_W-1:HALF];
    state_sel  = |umask[HALF-1:0];
    cyc_count  = '0;
    sel_valid  = 1'b0;
    case (kind)
      KIND_COUNT: begin
        sel_valid = 1'b1;
        cyc_count = CNT_W'(popcnt(masked));
      end
      KIND_LOOKUP: begin
        sel_valid = state_sel;
        if (state_sel && (!filt_on || filt_hit))
          cyc_count = CNT_W'(popcnt(state_bits));
      end
      KIND_OCCUP: begin
        sel_valid = 1'b1;
        cyc_count = CNT_W'(occ_val);
      end
      default: begin
        sel_valid = 1'b0;
        cyc_count = '0;
      end
    endcase
  end
endmodule

// File: rtl/qec_qualifier.sv
module qec_qualifier
  import qec_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel_valid,
  input  logic [CNT_W-1:0] cyc_count,
  input  logic [THR_W-1:0] thresh,
  input  logic             invert,
  input  logic             edge_en,
  input  logic             hist_clr,
  output logic [CNT_W-1:0] incr
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] thr_x;
  logic             thr_zero;
  logic             below;
  logic             cond;
  logic             prev_q;
  logic             prev_d;

  always_comb begin
    cnt_x    = CMP_W'(cyc_count);
    thr_x    = CMP_W'(thresh);
    thr_zero = (thresh == '0);
    below    = (cnt_x < thr_x);
    if (!sel_valid)    cond = 1'b0;
    else if (thr_zero) cond = (cyc_count != '0);
    else               cond = invert ? below : !below;

    if (!en)           incr = '0;
    else if (edge_en)  incr = CNT_W'(cond && !prev_q);
    else if (thr_zero) incr = sel_valid ? cyc_count : '0;
    else               incr = CNT_W'(cond);

    prev_d = (hist_clr || !en) ? 1'b0 : cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int CTR_W = 48,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  input  logic [CNT_W-1:0] incr,
  output logic [CTR_W-1:0] count_q
);
  logic             upd_en;
  logic [CTR_W-1:0] count_d;

  always_comb begin
    upd_en  = load || (incr != '0);
    count_d = load ? load_val : (count_q + CTR_W'(incr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (upd_en) count_q <= count_d;
  end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_vec,
  input  logic [OCC_W-1:0] occ_val,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CTR_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CTR_W-1:0] rd_data
);
  localparam int CNT_W = (OCC_W > POP_W) ? OCC_W : POP_W;

  logic             rst_sync_n;
  logic             cfg_wr;
  logic             ctr_wr;
  qec_cfg_t         cfg_q;
  qec_cfg_t         cfg_d;
  logic [CNT_W-1:0] cyc_count;
  logic             sel_valid;
  logic [CNT_W-1:0] incr;
  logic [CTR_W-1:0] cnt_q;

  qec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    cfg_wr = wr_en && !wr_sel;
    ctr_wr = wr_en && wr_sel;
    cfg_d  = cfg_wr ? qec_cfg_t'(wr_data[CFG_W-1:0]) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cfg_q <= '0;
    else if (cfg_wr)  cfg_q <= cfg_d;
  end

  qec_event_select #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_sel (
    .code      (cfg_q.code),
    .umask     (cfg_q.umask),
    .evt_vec   (evt_vec),
    .occ_val   (occ_val),
    .cyc_count (cyc_count),
    .sel_valid (sel_valid)
  );

  qec_qualifier #(.CNT_W(CNT_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (cfg_q.enable),
    .sel_valid (sel_valid),
    .cyc_count (cyc_count),
    .thresh    (cfg_q.thresh),
    .invert    (cfg_q.invert),
    .edge_en   (cfg_q.edge_en),
    .hist_clr  (cfg_wr),
    .incr      (incr)
  );

  qec_accum #(.CTR_W(CTR_W), .CNT_W(CNT_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ctr_wr),
    .load_val (wr_data),
    .incr     (incr),
    .count_q  (cnt_q)
  );

  always_comb begin
    rd_data = rd_sel ? cnt_q : CTR_W'(cfg_q);
  end
endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
  parameter int CTR_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             edge_en,
  input logic             thr_nz,
  input logic             lookup_blank,
  input logic             sel_valid,
  input logic             ctr_wr,
  input logic [CTR_W-1:0] wr_data,
  input logic [CTR_W-1:0] cnt_q
);
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr |=> (cnt_q == $past(wr_data))); // R11

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctr_wr) |=> $stable(cnt_q)); // R10

  AST_INVALID_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel_valid && !ctr_wr) |=> $stable(cnt_q)); // R9

  AST_BLANK_LOOKUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lookup_blank && !ctr_wr) |=> $stable(cnt_q)); // R7

  AST_EDGE_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_en && !ctr_wr) |=> (CTR_W'(cnt_q - $past(cnt_q)) <= CTR_W'(1))); // R6

  AST_THRESH_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && thr_nz && !ctr_wr) |=> (CTR_W'(cnt_q - $past(cnt_q)) <= CTR_W'(1))); // R4
endmodule

bind qual_event_counter qec_checker #(.CTR_W(CTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .en           (cfg_q.enable),
  .edge_en      (cfg_q.edge_en),
  .thr_nz       (cfg_q.thresh != 8'h00),
  .lookup_blank ((cfg_q.code == 8'h34) && (cfg_q.umask[3:0] == 4'h0)),
  .sel_valid    (sel_valid),
  .ctr_wr       (ctr_wr),
  .wr_data      (wr_data),
  .cnt_q        (cnt_q)
);

// File: tb/qual_event_counter_tb.sv
module qual_event_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CTR_W = 48;
  localparam int OCC_W = 6;

  logic             clk;
  logic             rst_n;
  logic [7:0]       evt_vec;
  logic [OCC_W-1:0] occ_val;
  logic             wr_en;
  logic             wr_sel;
  logic [CTR_W-1:0] wr_data;
  logic             rd_sel;
  logic [CTR_W-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic [7:0]       m_code, m_mask, m_thr;
  logic             m_edge, m_inv, m_en, m_prev;
  logic [CTR_W-1:0] m_cnt;

  qual_event_counter #(.CTR_W(CTR_W), .OCC_W(OCC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .occ_val(occ_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pop(input logic [7:0] v);
    int s = 0;
    for (int i = 0; i < 8; i++) s += int'(v[i]);
    return s;
  endfunction

  task automatic check(input string tag, input logic [CTR_W-1:0] act, input logic [CTR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive at falling edge, advance model, check next falling edge
  task automatic tick(input bit wr, input bit sel, input logic [CTR_W-1:0] wd,
                      input logic [7:0] ev, input logic [OCC_W-1:0] oc, input string tag);
    int  cnt;
    bit  valid, cond, filt_ok;
    int  inc;
    wr_en = wr; wr_sel = sel; wr_data = wd; evt_vec = ev; occ_val = oc;
    valid = 1'b0; cnt = 0;
    case (m_code)
      8'h22, 8'h81, 8'h84: begin valid = 1'b1; cnt = pop(ev & m_mask); end
      8'h34: begin
        valid   = (m_mask[3:0] != 4'h0);
        filt_ok = (m_mask[7:4] == 4'h0) || ((ev[7:4] & m_mask[7:4]) != 4'h0);
        cnt     = (valid && filt_ok) ? pop({4'h0, ev[3:0] & m_mask[3:0]}) : 0;
      end
      8'h80, 8'h83: begin valid = 1'b1; cnt = int'(oc); end
      default: begin valid = 1'b0; cnt = 0; end
    endcase
    if (!valid)            cond = 1'b0;
    else if (m_thr == 0)   cond = (cnt != 0);
    else if (m_inv)        cond = (cnt < int'(m_thr));
    else                   cond = (cnt >= int'(m_thr));
    if (!m_en)             inc = 0;
    else if (m_edge)       inc = (cond && !m_prev) ? 1 : 0;
    else if (m_thr == 0)   inc = valid ? cnt : 0;
    else                   inc = cond ? 1 : 0;
    m_prev = ((wr && !sel) || !m_en) ? 1'b0 : cond;
    if (wr && sel) m_cnt = wd;
    else           m_cnt = m_cnt + CTR_W'(inc);
    if (wr && !sel) begin
      m_code = wd[7:0]; m_mask = wd[15:8]; m_thr = wd[23:16];
      m_edge = wd[24];  m_inv = wd[25];    m_en = wd[26];
    end
    @(negedge clk);
    check(tag, rd_data, m_cnt);
  endtask

  function automatic logic [CTR_W-1:0] cfg_word(input logic [7:0] code, input logic [7:0] mask,
      input logic [7:0] thr, input bit edg, input bit inv, input bit en);
    logic [CTR_W-1:0] w = '0;
    w[7:0] = code; w[15:8] = mask; w[23:16] = thr;
    w[24] = edg; w[25] = inv; w[26] = en;
    return w;
  endfunction

  task automatic setup(input logic [7:0] code, input logic [7:0] mask, input logic [7:0] thr,
                       input bit edg, input bit inv, input bit en, input string tag);
    tick(1'b1, 1'b1, '0, 8'h00, '0, tag);
    tick(1'b1, 1'b0, cfg_word(code, mask, thr, edg, inv, en), 8'h00, '0, tag);
  endtask

  task automatic sweep_ev(input string tag);
    for (int e = 0; e < 256; e++) tick(1'b0, 1'b0, '0, 8'(e), 6'(e * 7), tag);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_vec = '0; occ_val = '0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_data = '0; rd_sel = 1'b1;
    m_code = '0; m_mask = '0; m_thr = '0; m_edge = 0; m_inv = 0; m_en = 0; m_prev = 0; m_cnt = '0;
    repeat (3) @(negedge clk);
    check("R1 counter in reset", rd_data, '0);
    rd_sel = 1'b0; #1;
    check("R1 config in reset", rd_data, '0);
    rd_sel = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 counter after reset", rd_data, '0);
    rd_sel = 1'b0; #1;
    check("R1 config after reset", rd_data, '0);
    rd_sel = 1'b1;

    // R2 register access
    tick(1'b1, 1'b0, 48'hFFFF_FD12_A534, 8'h00, '0, "R2 config write");
    rd_sel = 1'b0; #1;
    check("R2 config readback", rd_data, 48'h0000_0512_A534);
    rd_sel = 1'b1; #1;
    tick(1'b1, 1'b1, 48'h0123_4567_89AB, 8'h00, '0, "R2 counter write");
    tick(1'b1, 1'b0, '0, 8'h00, '0, "R2 config clear");

    // R3 plain counting
    setup(8'h22, 8'hFF, 8'd0, 0, 0, 1, "R3 setup");  sweep_ev("R3 code22 mask FF");
    setup(8'h81, 8'hA5, 8'd0, 0, 0, 1, "R3 setup");  sweep_ev("R3 code81 mask A5");
    setup(8'h84, 8'h0F, 8'd0, 0, 0, 1, "R3 setup");  sweep_ev("R3 code84 mask 0F");

    // R4 threshold
    for (int t = 1; t <= 9; t++) begin
      setup(8'h22, 8'hFF, 8'(t), 0, 0, 1, "R4 setup");
      sweep_ev("R4 threshold sweep");
    end
    // R5 invert
    for (int t = 1; t <= 9; t++) begin
      setup(8'h84, 8'hFF, 8'(t), 0, 1, 1, "R5 setup");
      sweep_ev("R5 inverted threshold sweep");
    end
    setup(8'h22, 8'h3C, 8'd0, 0, 1, 1, "R5 setup");
    sweep_ev("R5 invert ignored at threshold 0");

    // R6 edge
    setup(8'h22, 8'hFF, 8'd0, 1, 0, 1, "R6 setup");
    for (int i = 0; i < 256; i++) tick(1'b0, 1'b0, '0, ((i >> 2) & 1) ? 8'(i * 29 + 1) : 8'h00, '0, "R6 edge thr0");
    setup(8'h81, 8'hFF, 8'd3, 1, 0, 1, "R6 setup");
    for (int i = 0; i < 256; i++) tick(1'b0, 1'b0, '0, 8'(i * 53), '0, "R6 edge thr3");
    setup(8'h22, 8'hFF, 8'd0, 1, 0, 1, "R6 setup");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, '0, 8'hFF, '0, "R6 held condition");
    tick(1'b1, 1'b0, cfg_word(8'h22, 8'hFF, 8'd0, 1, 0, 1), 8'hFF, '0, "R6 rewrite config");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, '0, 8'hFF, '0, "R6 history cleared by write");
    tick(1'b1, 1'b0, cfg_word(8'h22, 8'hFF, 8'd0, 1, 0, 0), 8'hFF, '0, "R6 disable");
    tick(1'b0, 1'b0, '0, 8'hFF, '0, "R6 disabled");
    tick(1'b1, 1'b0, cfg_word(8'h22, 8'hFF, 8'd0, 1, 0, 1), 8'hFF, '0, "R6 re-enable");
    tick(1'b0, 1'b0, '0, 8'hFF, '0, "R6 history cleared by disable");

    // R7 lookup filters
    setup(8'h34, 8'hF0, 8'd0, 0, 0, 1, "R7 setup"); sweep_ev("R7 filter-only mask");
    setup(8'h34, 8'hF0, 8'd2, 0, 1, 1, "R7 setup"); sweep_ev("R7 filter-only mask inverted");
    setup(8'h34, 8'h0F, 8'd0, 0, 0, 1, "R7 setup"); sweep_ev("R7 state bits only");
    setup(8'h34, 8'h35, 8'd0, 0, 0, 1, "R7 setup"); sweep_ev("R7 state plus filters");
    setup(8'h34, 8'hC6, 8'd2, 0, 0, 1, "R7 setup"); sweep_ev("R7 filtered threshold");

    // R8 occupancy
    setup(8'h80, 8'h00, 8'd0, 0, 0, 1, "R8 setup");
    for (int o = 0; o < 64; o++) tick(1'b0, 1'b0, '0, 8'(o * 11), 6'(o), "R8 code80 weighted add");
    setup(8'h83, 8'h5A, 8'd20, 0, 0, 1, "R8 setup");
    for (int o = 0; o < 64; o++) tick(1'b0, 1'b0, '0, 8'hFF, 6'(o), "R8 code83 threshold");
    setup(8'h83, 8'h01, 8'd20, 0, 1, 1, "R8 setup");
    for (int o = 0; o < 64; o++) tick(1'b0, 1'b0, '0, 8'h00, 6'(63 - o), "R8 code83 inverted");

    // R9 unsupported codes
    setup(8'h55, 8'hFF, 8'd0, 0, 0, 1, "R9 setup"); sweep_ev("R9 unsupported plain");
    setup(8'h00, 8'hFF, 8'd4, 0, 1, 1, "R9 setup"); sweep_ev("R9 unsupported inverted");
    setup(8'h82, 8'hFF, 8'd0, 1, 0, 1, "R9 setup"); sweep_ev("R9 unsupported edge");

    // R10 disabled
    setup(8'h22, 8'hFF, 8'd0, 0, 0, 0, "R10 setup"); sweep_ev("R10 disabled plain");
    setup(8'h80, 8'hFF, 8'd5, 0, 1, 0, "R10 setup"); sweep_ev("R10 disabled inverted");

    // R11 write priority and wrap
    setup(8'h22, 8'hFF, 8'd0, 0, 0, 1, "R11 setup");
    tick(1'b0, 1'b0, '0, 8'hFF, '0, "R11 counting");
    tick(1'b1, 1'b1, 48'h0000_0000_1000, 8'hFF, '0, "R11 write beats increment");
    tick(1'b0, 1'b0, '0, 8'hFF, '0, "R11 resume after write");
    setup(8'h80, 8'h00, 8'd0, 0, 0, 1, "R11 setup");
    tick(1'b1, 1'b1, 48'hFFFF_FFFF_FFF0, 8'h00, 6'd63, "R11 preload near top");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, '0, 8'h00, 6'd7, "R11 wrap");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule